// File: doc/BRIEF.md
# Serial Bit-Exchange Reorder Stage

This block sits between two processing stages of a serial-commutator FFT pipeline that carries one sample per clock. Its job is to reorder the stream so that the two samples the next butterfly combines arrive on back-to-back cycles. It does this by exchanging bit `K` and bit 0 of each sample's position in the stream. The exchange uses a short delay line of `L = 2^K - 1` registers placed between two 2:1 multiplexers, with no frame-sized buffer.

The stage position is set by the parameters `LOG2N` (the transform has `2^LOG2N` points) and `STAGE`. Together they give `K = LOG2N - STAGE - 1`, so later stages use shorter lines. For a 16-point transform, stage 1 needs three registers and stage 2 needs one. The circuit is the same for decimation-in-frequency and decimation-in-time flows; only the stage parameter changes.

An accepted sample is one presented with `in_valid` high. The block counts accepted samples, so gaps in `in_valid` stall the reorder without losing alignment.

Top module: `sc_bit_exchange`

## Requirements
- R1: The line length is `L = 2^K - 1` with `K = LOG2N - STAGE - 1` (K must be at least 1). Counting accepted samples from 0 after reset, the first output appears one cycle after accepted sample number `L`.
- R2: Output slot `j` carries the input with index `j`, except that bit K and bit 0 of the index are exchanged. The pattern repeats every `2^(K+1)` samples. The output for accepted sample `g` (with `g >= L`) is slot `g - L`.
- R3: `out_valid` is high in the cycle after an accepted sample with index `g >= L`. It is low after any accepted sample with a smaller index.
- R4: When `in_valid` is low, `in_data` is ignored. The counter and the delay line hold their contents, `out_valid` is low in the next cycle, and `out_data` keeps its value.
- R5: An input whose index has bit K = 1 and bit 0 = 0 takes the bypass path. It appears on `out_data` in the very next cycle.
- R6: The reset `rst` is synchronous and active high. It clears the sample counter, the fill count, the delay registers, `out_data` (to 0) and `out_valid`. Sample indexing restarts at 0 afterwards.
- R7: Once the line has filled, a continuous input stream gives a continuous output stream. Back-to-back frames pass with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample is valid this cycle |
| in_data | input | WIDTH | Input sample word |
| out_valid | output | 1 | Output sample is valid |
| out_data | output | WIDTH | Reordered sample word (registered) |

## Verification
The embedded assertions check several properties on every cycle:
- the counter and the line hold still while `in_valid` is low;
- `out_data` stays unchanged during idle cycles;
- a bypass-class input reaches the output exactly one cycle later;
- `out_valid` is never raised without an accepted sample the cycle before;
- once filled, the block keeps producing output for every accepted sample;
- reset leaves the outputs cleared.

The full permutation across a period, the exact fill point, and recovery from a reset in the middle of a stream can only be shown by the bench. It drives continuous, gapped and interrupted streams into two stage settings and compares every output against a behavioural index-swap model.

// File: rtl/sc_bx_pkg.sv
package sc_bx_pkg;

    // Which path the two multiplexers take for the current sample.
    typedef enum logic {
        ROUTE_LINE = 1'b0,  // line takes input, output takes line tail
        ROUTE_EXCH = 1'b1   // line recirculates, output takes input directly
    } route_e;

    // Index bit that is exchanged with bit 0 at a given stage.
    function automatic int xchg_bit(input int log2n, input int stage);
        return log2n - stage - 1;
    endfunction

    // Number of delay registers needed at a given stage.
    function automatic int line_len(input int log2n, input int stage);
        return (1 << xchg_bit(log2n, stage)) - 1;
    endfunction

endpackage

// File: rtl/sc_bx_ctrl.sv
module sc_bx_ctrl
    import sc_bx_pkg::*;
#(
    parameter int K = 2,
    parameter int L = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    output route_e route,
    output logic   primed
);
    localparam int CW = K + 1;
    localparam int FW = $clog2(L + 1);

    logic [CW-1:0] cnt;
    logic [FW-1:0] fill;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            fill <= '0;
        end else if (adv) begin
            cnt <= cnt + 1'b1;
            if (!primed) fill <= fill + 1'b1;
        end
    end

    assign primed = (fill == FW'(L));

    // Bypass class: index bit K set and bit 0 clear.
    assign route = (cnt[K] && !cnt[0]) ? ROUTE_EXCH : ROUTE_LINE;

    a_r4_count_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt));

    a_r3_fill_sticky: assert property (@(posedge clk) disable iff (rst)
        primed |=> primed);

    a_r6_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt == '0 && !primed));

endmodule

// File: rtl/sc_bx_line.sv
module sc_bx_line #(
    parameter int W = 16,
    parameter int L = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < L; i++) begin : g_tap
        logic [W-1:0] d;
        logic [W-1:0] q;
        if (i == 0) begin : g_head
            assign d = din;
        end else begin : g_body
            assign d = g_tap[i-1].q;
        end
        always_ff @(posedge clk) begin
            if (rst)     q <= '0;
            else if (en) q <= d;
        end
    end

    assign dout = g_tap[L-1].q;

    a_r4_line_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(dout));

endmodule

// File: rtl/sc_bit_exchange.sv
module sc_bit_exchange
    import sc_bx_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int LOG2N = 4,
    parameter int STAGE = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data
);
    localparam int K = xchg_bit(LOG2N, STAGE);
    localparam int L = line_len(LOG2N, STAGE);

    route_e           route;
    logic             primed;
    logic [WIDTH-1:0] line_in;
    logic [WIDTH-1:0] line_out;
    logic [WIDTH-1:0] sel_out;

    sc_bx_ctrl #(.K(K), .L(L)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .adv    (in_valid),
        .route  (route),
        .primed (primed)
    );

    // Entry multiplexer: recirculate the tail on a bypass sample.
    assign line_in = (route == ROUTE_EXCH) ? line_out : in_data;

    sc_bx_line #(.W(WIDTH), .L(L)) u_line (
        .clk  (clk),
        .rst  (rst),
        .en   (in_valid),
        .din  (line_in),
        .dout (line_out)
    );

    // Exit multiplexer.
    assign sel_out = (route == ROUTE_EXCH) ? in_data : line_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid && primed;
            if (in_valid && primed) out_data <= sel_out;
        end
    end

    a_r5_bypass_next: assert property (@(posedge clk) disable iff (rst)
        (in_valid && primed && route == ROUTE_EXCH) |=> (out_data == $past(in_data)));

    a_r3_valid_source: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    a_r4_data_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_data)));

    a_r7_no_gap: assert property (@(posedge clk) disable iff (rst)
        (in_valid && primed) |=> out_valid);

    a_r6_reset_out: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_data == '0));

endmodule

// File: tb/sc_bit_exchange_tb.sv
module sc_bit_exchange_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int LOG2N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         ov [2];
    logic [W-1:0] od [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_bit_exchange #(.WIDTH(W), .LOG2N(LOG2N), .STAGE(1)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov[0]), .out_data(od[0]));

    sc_bit_exchange #(.WIDTH(W), .LOG2N(LOG2N), .STAGE(2)) u_dut_s2 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov[1]), .out_data(od[1]));

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [W-1:0] hist [$];
    int           g = 0;
    int           kk [2] = '{2, 1};
    int           ll [2] = '{3, 1};
    logic         exp_v [2] = '{1'b0, 1'b0};
    logic [W-1:0] exp_d [2] = '{16'h0, 16'h0};
    string        vtag [2];
    string        dtag [2];
    bit           armed = 1'b0;
    bit           cont_phase = 1'b0;

    function automatic int perm(input int j, input int k);
        int bk = (j >> k) & 1;
        int b0 = j & 1;
        int r = j & ~((1 << k) | 1);
        return r | (b0 << k) | bk;
    endfunction

    task automatic compare();
        for (int i = 0; i < 2; i++) begin
            checks++;
            if (ov[i] !== exp_v[i]) begin
                errors++;
                $display("FAIL %s dut%0d out_valid actual=%b expected=%b", vtag[i], i, ov[i], exp_v[i]);
            end
            checks++;
            if (od[i] !== exp_d[i]) begin
                errors++;
                $display("FAIL %s dut%0d out_data actual=%h expected=%h", dtag[i], i, od[i], exp_d[i]);
            end
        end
    endtask

    task automatic step(input bit r, input bit v, input logic [W-1:0] d);
        @(negedge clk);
        if (armed) compare();
        rst = r;
        in_valid = v;
        in_data = d;
        if (r) begin
            hist.delete();
            g = 0;
            for (int i = 0; i < 2; i++) begin
                exp_v[i] = 1'b0; exp_d[i] = '0;
                vtag[i] = "R6"; dtag[i] = "R6";
            end
            armed = 1'b1;
        end else if (v) begin
            hist.push_back(d);
            for (int i = 0; i < 2; i++) begin
                if (g >= ll[i]) begin
                    int j = g - ll[i];
                    exp_v[i] = 1'b1;
                    exp_d[i] = hist[perm(j, kk[i])];
                    vtag[i] = (g == ll[i]) ? "R1" : (cont_phase ? "R7" : "R3");
                    dtag[i] = (((g >> kk[i]) & 1) == 1 && (g & 1) == 0) ? "R5" : "R2";
                end else begin
                    exp_v[i] = 1'b0;
                    vtag[i] = "R3"; dtag[i] = "R3";
                end
            end
            g++;
        end else begin
            for (int i = 0; i < 2; i++) begin
                exp_v[i] = 1'b0;
                vtag[i] = "R4"; dtag[i] = "R4";
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 16'hdead);
        // continuous frames, back to back
        cont_phase = 1'b1;
        for (int i = 0; i < 64; i++) step(1'b0, 1'b1, W'(16'h1000 + i * 7));
        cont_phase = 1'b0;
        // idle with changing data: must be ignored
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, W'($urandom));
        // gapped stream
        for (int i = 0; i < 96; i++) step(1'b0, ($urandom % 3) != 0, W'($urandom));
        // reset in the middle of a frame
        for (int i = 0; i < 2; i++) step(1'b1, 1'b1, W'($urandom));
        cont_phase = 1'b1;
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1, W'(16'h8000 ^ (i * 13)));
        cont_phase = 1'b0;
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, W'($urandom));
        for (int i = 0; i < 50; i++) step(1'b0, ($urandom % 2) == 0, W'($urandom));
        step(1'b0, 1'b0, '0);
        step(1'b0, 1'b0, '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule